// File: doc/BRIEF.md
# Horizontal Pixel Panning Shifter

This block moves each displayed scanline to the left by a programmable number of pixels. Pixels enter one per clock. They pass through a short chain of registers. The output taps that chain at a point chosen by the effective shift, so a larger shift gives a shorter delay. The tap is picked when a line begins and is held for the whole line.

A 4-bit panning code is turned into a shift count by a table that depends on the display mode. Three modes are supported: 9-dot text, 256-colour and all others. An optional split override forces the shift to zero once a line-compare event has fired. The override stays in force until the next vertical retrace, after which the programmed value applies again. Pixel fetch and display timing come from outside the block.

Top module: `pan_shifter`

## Requirements
- R1: With `mode_i` = 0 or 3 (other modes), codes 0 to 7 give a shift equal to the code. Codes 8 to 15 give a shift of 0.
- R2: With `mode_i` = 1 (9-dot text), codes 0 to 7 give a shift of code+1. Code 8 gives 0, and codes 9 to 15 give 0.
- R3: With `mode_i` = 2 (256-colour), the even codes 0, 2, 4 and 6 give 0, 1, 2 and 3. Odd codes and codes 8 or above give 0.
- R4: `shift_o` is loaded only on a clock edge where `line_start_i` is high. A change of `pan_i` or `mode_i` at any other time takes effect at the next line start.
- R5: `pix_o` equals `pix_i` delayed by 9 − `shift_o` clocks. A shift of 8 gives 1 clock and a shift of 0 gives 9 clocks.
- R6: When `split_en_i` is high, a `lc_hit_i` pulse forces a shift of 0. This includes a line start in the same cycle, and every later line start until a vertical retrace.
- R7: A `vretrace_i` pulse ends the override, so later lines use the programmed shift. If `vretrace_i` and `lc_hit_i` are high in the same cycle, the retrace wins and no override starts.
- R8: When `split_en_i` is low, `lc_hit_i` has no effect on the shift.
- R9: After reset, `shift_o` = 0, `pix_o` = 0 and no override is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Incoming pixel, one per clock |
| line_start_i | input | 1 | High for one clock at the start of a scanline |
| pan_i | input | 4 | Programmed panning code |
| mode_i | input | 2 | Display mode: 0 other, 1 9-dot text, 2 256-colour, 3 other |
| split_en_i | input | 1 | Enables the line-compare override |
| lc_hit_i | input | 1 | Line-compare event pulse |
| vretrace_i | input | 1 | Vertical retrace pulse |
| pix_o | output | 8 | Shifted pixel stream |
| shift_o | output | 4 | Effective shift for the current line |

## Verification
A line-compare pulse can arrive in the same cycle as a line start or as a vertical retrace. The bench drives both pairings directly.

When the pulse comes with a line start and the override is enabled, the line that starts must already show a shift of zero. When the pulse comes with a retrace, no override may start: the same line and the following one must show the programmed shift. Both results are judged from `shift_o` on the clock after the event.

// File: rtl/pan_pkg.sv
package pan_pkg;
  typedef enum logic [1:0] {
    MODE_OTHER  = 2'd0,
    MODE_TEXT9  = 2'd1,
    MODE_C256   = 2'd2,
    MODE_OTHER2 = 2'd3
  } pan_mode_e;
endpackage

// File: rtl/pan_map.sv
module pan_map import pan_pkg::*; #(
  parameter int PAN_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic [PAN_W-1:0] pan_i,
  input  logic [1:0]       mode_i,
  output logic [SH_W-1:0]  shift_o
);
  localparam logic [PAN_W-1:0] PanLim = PAN_W'(MAX_SHIFT);

  always_comb begin
    shift_o = '0;
    unique case (pan_mode_e'(mode_i))
      MODE_TEXT9: if (pan_i < PanLim) shift_o = SH_W'(pan_i) + SH_W'(1);
      MODE_C256:  if (!pan_i[0] && pan_i < PanLim) shift_o = SH_W'(pan_i >> 1);
      default:    if (pan_i < PanLim) shift_o = SH_W'(pan_i);
    endcase
  end
endmodule

// File: rtl/pan_split.sv
module pan_split (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic split_en_i,
  input  logic lc_hit_i,
  input  logic vretrace_i,
  output logic force_zero_o,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     armed_q <= 1'b0;
    else if (vretrace_i)             armed_q <= 1'b0;
    else if (split_en_i && lc_hit_i) armed_q <= 1'b1;
  end

  // retrace has priority; a hit counts already for a coincident line start
  assign force_zero_o = split_en_i && !vretrace_i && (armed_q || lc_hit_i);
  assign armed_o      = armed_q;
endmodule

// File: rtl/pan_delay.sv
module pan_delay #(
  parameter int PIX_W     = 8,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int Taps = MAX_SHIFT + 1;

  logic [PIX_W-1:0] tap_q [Taps];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q[0] <= '0;
    else         tap_q[0] <= pix_i;
  end

  for (genvar g = 1; g < Taps; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[g] <= '0;
      else         tap_q[g] <= tap_q[g-1];
    end
  end

  logic [SH_W-1:0] sel;
  assign sel   = SH_W'(MAX_SHIFT) - shift_i;
  assign pix_o = tap_q[sel];
endmodule

// File: rtl/pan_shifter.sv
module pan_shifter import pan_pkg::*; #(
  parameter int PIX_W     = 8,
  parameter int PAN_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             line_start_i,
  input  logic [PAN_W-1:0] pan_i,
  input  logic [1:0]       mode_i,
  input  logic             split_en_i,
  input  logic             lc_hit_i,
  input  logic             vretrace_i,
  output logic [PIX_W-1:0] pix_o,
  output logic [SH_W-1:0]  shift_o
);
  logic [SH_W-1:0] mapped;
  logic            force_zero;
  logic            armed;
  logic [SH_W-1:0] shift_q;

  pan_map #(.PAN_W(PAN_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) i_map (
    .pan_i   (pan_i),
    .mode_i  (mode_i),
    .shift_o (mapped)
  );

  pan_split i_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .split_en_i   (split_en_i),
    .lc_hit_i     (lc_hit_i),
    .vretrace_i   (vretrace_i),
    .force_zero_o (force_zero),
    .armed_o      (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           shift_q <= '0;
    else if (line_start_i) shift_q <= force_zero ? '0 : mapped;
  end

  pan_delay #(.PIX_W(PIX_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) i_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_i   (pix_i),
    .shift_i (shift_q),
    .pix_o   (pix_o)
  );

  assign shift_o = shift_q;
endmodule

// File: rtl/pan_shifter_chk.sv
module pan_shifter_chk #(
  parameter int PIX_W     = 8,
  parameter int PAN_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PIX_W-1:0] pix_i,
  input logic             line_start_i,
  input logic [PAN_W-1:0] pan_i,
  input logic [1:0]       mode_i,
  input logic             split_en_i,
  input logic             lc_hit_i,
  input logic             vretrace_i,
  input logic             armed,
  input logic [PIX_W-1:0] pix_o,
  input logic [SH_W-1:0]  shift_o
);
  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o <= SH_W'(MAX_SHIFT));

  p_other_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !split_en_i && mode_i == 2'd0 && pan_i < PAN_W'(MAX_SHIFT))
      |=> shift_o == SH_W'($past(pan_i)));

  p_text_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !split_en_i && mode_i == 2'd1 && pan_i == PAN_W'(MAX_SHIFT))
      |=> shift_o == '0);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(shift_o));

  p_min_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o == SH_W'(MAX_SHIFT)) |-> pix_o == $past(pix_i));

  p_split_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && split_en_i && lc_hit_i && !vretrace_i) |=> shift_o == '0);

  p_retrace_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vretrace_i |=> !armed);

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (shift_o == '0 && pix_o == '0 && !armed));
endmodule

bind pan_shifter pan_shifter_chk #(
  .PIX_W(PIX_W), .PAN_W(PAN_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .line_start_i(line_start_i),
  .pan_i(pan_i), .mode_i(mode_i), .split_en_i(split_en_i), .lc_hit_i(lc_hit_i),
  .vretrace_i(vretrace_i), .armed(armed), .pix_o(pix_o), .shift_o(shift_o)
);

// File: tb/test_pan_shifter.sv
`timescale 1ns/1ps
module test_pan_shifter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pix_i = '0;
  logic       line_start_i = 1'b0;
  logic [3:0] pan_i = '0;
  logic [1:0] mode_i = '0;
  logic       split_en_i = 1'b0;
  logic       lc_hit_i = 1'b0;
  logic       vretrace_i = 1'b0;
  logic [7:0] pix_o;
  logic [3:0] shift_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  pan_shifter i_pan_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .line_start_i(line_start_i),
    .pan_i(pan_i), .mode_i(mode_i), .split_en_i(split_en_i), .lc_hit_i(lc_hit_i),
    .vretrace_i(vretrace_i), .pix_o(pix_o), .shift_o(shift_o)
  );

  // {mode, pan, expected shift}
  localparam logic [9:0] VEC [16] = '{
    {2'd0, 4'd0, 4'd0}, {2'd0, 4'd7, 4'd7}, {2'd0, 4'd8, 4'd0}, {2'd0, 4'd15, 4'd0},
    {2'd3, 4'd4, 4'd4}, {2'd1, 4'd0, 4'd1}, {2'd1, 4'd7, 4'd8}, {2'd1, 4'd8, 4'd0},
    {2'd1, 4'd9, 4'd0}, {2'd1, 4'd3, 4'd4}, {2'd2, 4'd0, 4'd0}, {2'd2, 4'd2, 4'd1},
    {2'd2, 4'd6, 4'd3}, {2'd2, 4'd1, 4'd0}, {2'd2, 4'd8, 4'd0}, {2'd2, 4'd5, 4'd0}
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic new_line(input logic lc, input logic vr);
    line_start_i = 1'b1; lc_hit_i = lc; vretrace_i = vr;
    tick();
    line_start_i = 1'b0; lc_hit_i = 1'b0; vretrace_i = 1'b0;
  endtask

  task automatic lat_test(input logic [1:0] m, input logic [3:0] p, input int s);
    int lat;
    mode_i = m; pan_i = p; split_en_i = 1'b0;
    new_line(1'b0, 1'b0);
    chk("R5 shift", int'(shift_o), s);
    lat = 9 - s;
    for (int c = 0; c < 20; c++) begin
      pix_i = 8'(100 + c);
      tick();
      if (c - lat + 1 >= 0) chk("R5 pixel", int'(pix_o), 100 + c - lat + 1);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pix_i = 8'h5A;
    tick(); tick();
    chk("R9 shift", int'(shift_o), 0);
    chk("R9 pix", int'(pix_o), 0);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < 16; i++) begin
      mode_i = VEC[i][9:8]; pan_i = VEC[i][7:4];
      new_line(1'b0, 1'b0);
      chk(VEC[i][9:8] == 2'd1 ? "R2 map" : VEC[i][9:8] == 2'd2 ? "R3 map" : "R1 map",
          int'(shift_o), int'(VEC[i][3:0]));
    end

    // R4: mid-line change held until next line start
    mode_i = 2'd0; pan_i = 4'd5;
    new_line(1'b0, 1'b0);
    pan_i = 4'd2; mode_i = 2'd1;
    tick(); tick(); tick();
    chk("R4 hold", int'(shift_o), 5);
    new_line(1'b0, 1'b0);
    chk("R4 next line", int'(shift_o), 3);

    // R5: latency per shift
    lat_test(2'd0, 4'd0, 0);
    lat_test(2'd1, 4'd7, 8);
    lat_test(2'd0, 4'd3, 3);

    // R8: compare ignored when disabled
    mode_i = 2'd0; pan_i = 4'd5; split_en_i = 1'b0;
    new_line(1'b1, 1'b0);
    chk("R8 ignored", int'(shift_o), 5);
    new_line(1'b0, 1'b0);
    chk("R8 ignored next", int'(shift_o), 5);

    // R6: compare coincident with line start forces zero until retrace
    split_en_i = 1'b1;
    new_line(1'b0, 1'b0);
    chk("R6 before", int'(shift_o), 5);
    new_line(1'b1, 1'b0);
    chk("R6 same cycle", int'(shift_o), 0);
    new_line(1'b0, 1'b0);
    chk("R6 held", int'(shift_o), 0);

    // R7: retrace restores
    vretrace_i = 1'b1; tick(); vretrace_i = 1'b0;
    chk("R7 no reload mid-line", int'(shift_o), 0);
    new_line(1'b0, 1'b0);
    chk("R7 restored", int'(shift_o), 5);

    // R7: compare and retrace together, retrace wins
    new_line(1'b1, 1'b1);
    chk("R7 coincident", int'(shift_o), 5);
    new_line(1'b0, 1'b0);
    chk("R7 coincident next", int'(shift_o), 5);

    // R6: compare mid-line, applies at next line
    lc_hit_i = 1'b1; tick(); lc_hit_i = 1'b0;
    chk("R6 mid-line hold", int'(shift_o), 5);
    new_line(1'b0, 1'b0);
    chk("R6 next line", int'(shift_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule